// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Acknowledge Gating

This block keeps the return addresses of a small processor core in an eight-entry hardware stack, and it decides when a pending interrupt may be acknowledged. The core raises a call strobe with the address to save. It raises a return or a return-from-interrupt strobe to take the newest saved address back. That address is always visible on the pop data bus. There is no path for software to read or write the entries or the fill pointer.

Three interrupt sources each have a request input and an enable input. Every request is latched into a flag. A flag is acknowledged when four things hold: its source is enabled, the global enable is set, the stack has a free level, and the core is not issuing a stack strobe in that cycle. The acknowledge saves the address on the push bus in the same clock edge and clears the global enable. A return-from-interrupt sets the global enable again. When the stack is full, a pending flag waits. It is acknowledged in the first free cycle after a pop has made room. Vector address generation sits outside this block.

Top module: `ret_stack_irq`

## Requirements
- R1: A synchronous active-high reset empties the stack (`empty_o`=1, `full_o`=0, `pop_addr_o`=0) and clears every request flag and the global enable.
- R2: A call stores `push_addr_i`. `pop_addr_o` always shows the newest stored address, or zero while the stack is empty. A return or return-from-interrupt removes that newest address.
- R3: `full_o` rises after eight stores without removal. A further call while full is still stored: the oldest entry is discarded, `full_o` stays 1 and nothing flags the loss.
- R4: A pop strobe while the stack is empty changes nothing. The stack stays empty and `pop_addr_o` stays zero.
- R5: A call together with a return in the same cycle replaces the newest entry with `push_addr_i` and leaves the depth unchanged.
- R6: A request pulse on bit i of `irq_req_i` (bit 0 external, bit 1 timer 0, bit 2 timer 1) sets flag i on the next edge, whatever the enables are. The flag stays set until that source is acknowledged.
- R7: `irq_ack_o` is one-hot or zero and combinational. It selects the lowest-numbered flag whose enable is set, but only while the global enable is 1, the stack is not full and no call, return or return-from-interrupt strobe is active. At that edge the block stores `push_addr_i`, clears that flag and clears the global enable.
- R8: While the stack is full no acknowledge is given and flags are kept. In the first strobe-free cycle after a pop frees a level, the pending flag is acknowledged.
- R9: A return-from-interrupt sets the global enable. A plain return leaves it unchanged.
- R10: `gie_set_i` sets the global enable and `gie_clr_i` clears it. When both are active, clear wins, and an acknowledge clears it regardless.
- R11: A flag whose source is disabled is never acknowledged. It is acknowledged once its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Subroutine call strobe: store `push_addr_i` |
| ret_i | input | 1 | Return strobe: remove newest entry |
| reti_i | input | 1 | Return-from-interrupt strobe: remove newest entry, set global enable |
| push_addr_i | input | 15 | Address stored on a call or an acknowledge |
| pop_addr_o | output | 15 | Newest stored address, zero when empty |
| full_o | output | 1 | All eight levels occupied |
| empty_o | output | 1 | No level occupied |
| irq_req_i | input | 3 | Request pulses: bit 0 external, bit 1 timer 0, bit 2 timer 1 |
| irq_en_i | input | 3 | Per-source enables, same bit order |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| irq_ack_o | output | 3 | One-hot acknowledge, same bit order |
| irq_flag_o | output | 3 | Latched request flags |
| gie_o | output | 1 | Global interrupt enable |

## Verification
A wrong fill pointer or count shows at the ports within one clock edge. `pop_addr_o` then presents the wrong address, or `full_o` and `empty_o` take the wrong value. The acknowledge gating is visible when a level is released: the pending flag must be acknowledged in the first strobe-free cycle after the pop, not before and not later. An overflow that was mishandled stays hidden until the stack is drained, so the bench drains it completely and compares every address in newest-first order. Priority or enable faults show as the wrong one-hot bit, or as a flag that clears without an acknowledge.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DEPTH = 8;
    localparam int RS_AW    = 15;
    localparam int RS_NSRC  = 3;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic ack;
        logic clr;
        logic set;
        logic reti;
    } gie_ctl_t;

    function automatic stk_op_e op_decode(input logic push, input logic pop);
        stk_op_e op;
        case ({push, pop})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
        return op;
    endfunction

    // Acknowledge dominates, then clear, then any setting source.
    function automatic logic gie_update(input gie_ctl_t c, input logic cur);
        logic nxt;
        if (c.ack || c.clr)
            nxt = 1'b0;
        else if (c.set || c.reti)
            nxt = 1'b1;
        else
            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/rs_store.sv
module rs_store
    import rs_pkg::*;
#(
    parameter int DEPTH = RS_DEPTH,
    parameter int AW    = RS_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_e       op,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic          full,
    output logic          empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [AW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] ptr;        // next free slot (circular)
    logic [CNT_W-1:0] cnt;        // occupied levels, saturates at DEPTH
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic             do_store;
    logic [PTR_W-1:0] store_idx;

    assign ptr_inc = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    assign ptr_dec = (ptr == '0) ? PTR_LAST : ptr - 1'b1;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_FULL);
    assign rdata = empty ? '0 : mem[ptr_dec];

    // A swap on an empty stack degenerates into a plain push.
    always_comb begin
        do_store  = 1'b0;
        store_idx = ptr;
        case (op)
            OP_PUSH: do_store = 1'b1;
            OP_SWAP: begin
                do_store  = 1'b1;
                store_idx = empty ? ptr : ptr_dec;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (do_store)
            mem[store_idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            cnt <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    ptr <= ptr_inc;
                    if (!full)
                        cnt <= cnt + 1'b1;
                end
                OP_POP: begin
                    if (!empty) begin
                        ptr <= ptr_dec;
                        cnt <= cnt - 1'b1;
                    end
                end
                OP_SWAP: begin
                    if (empty) begin
                        ptr <= ptr_inc;
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rs_irq_gate.sv
module rs_irq_gate
    import rs_pkg::*;
#(
    parameter int NSRC = RS_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic            gie_set,
    input  logic            gie_clr,
    input  logic            reti,
    input  logic            busy,
    input  logic            full,
    output logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] flags,
    output logic            gie
);

    logic [NSRC-1:0] cand;
    logic            allow;
    logic            taken;
    gie_ctl_t        ctl;

    assign cand  = flags & en;
    assign allow = gie && !full && !busy;

    // Fixed priority: lowest index wins.
    always_comb begin
        ack   = '0;
        taken = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (allow && cand[i] && !taken) begin
                ack[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    assign ctl = '{ack: |ack, clr: gie_clr, set: gie_set, reti: reti};

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            gie   <= 1'b0;
        end else begin
            flags <= (flags | req) & ~ack;
            gie   <= gie_update(ctl, gie);
        end
    end

endmodule

// File: rtl/ret_stack_irq.sv
module ret_stack_irq
    import rs_pkg::*;
#(
    parameter int DEPTH = RS_DEPTH,
    parameter int AW    = RS_AW,
    parameter int NSRC  = RS_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            reti_i,
    input  logic [AW-1:0]   push_addr_i,
    output logic [AW-1:0]   pop_addr_o,
    output logic            full_o,
    output logic            empty_o,
    input  logic [NSRC-1:0] irq_req_i,
    input  logic [NSRC-1:0] irq_en_i,
    input  logic            gie_set_i,
    input  logic            gie_clr_i,
    output logic [NSRC-1:0] irq_ack_o,
    output logic [NSRC-1:0] irq_flag_o,
    output logic            gie_o
);

    logic    busy;
    logic    push;
    logic    pop;
    stk_op_e op;

    assign busy = call_i | ret_i | reti_i;
    assign push = call_i | (|irq_ack_o);
    assign pop  = ret_i | reti_i;
    assign op   = op_decode(push, pop);

    rs_irq_gate #(.NSRC(NSRC)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req_i),
        .en      (irq_en_i),
        .gie_set (gie_set_i),
        .gie_clr (gie_clr_i),
        .reti    (reti_i),
        .busy    (busy),
        .full    (full_o),
        .ack     (irq_ack_o),
        .flags   (irq_flag_o),
        .gie     (gie_o)
    );

    rs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (push_addr_i),
        .rdata (pop_addr_o),
        .full  (full_o),
        .empty (empty_o)
    );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int AW   = 15,
    parameter int NSRC = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            call_i,
    input logic            ret_i,
    input logic            reti_i,
    input logic [AW-1:0]   pop_addr_o,
    input logic            full_o,
    input logic            empty_o,
    input logic            gie_clr_i,
    input logic [NSRC-1:0] irq_ack_o,
    input logic [NSRC-1:0] irq_flag_o,
    input logic            gie_o
);

    a_r1_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> (pop_addr_o == '0));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full_o && call_i && !ret_i && !reti_i) |=> full_o);

    a_r4_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (empty_o && !call_i && !(|irq_ack_o)) |=> empty_o);

    a_r6_flag_held: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((irq_flag_o & $past(irq_flag_o & ~irq_ack_o))
                  == $past(irq_flag_o & ~irq_ack_o)));

    a_r7_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack_o));

    a_r7_ack_needs_gie: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack_o) |-> (gie_o && (irq_ack_o & irq_flag_o) == irq_ack_o));

    a_r7_ack_clears_gie: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack_o) |=> !gie_o);

    a_r8_full_blocks_ack: assert property (@(posedge clk) disable iff (rst)
        full_o |-> (irq_ack_o == '0));

    a_r9_reti_sets_gie: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !gie_clr_i) |=> gie_o);

    a_r10_clr_wins: assert property (@(posedge clk) disable iff (rst)
        gie_clr_i |=> !gie_o);

endmodule

bind ret_stack_irq rs_checker #(.AW(AW), .NSRC(NSRC)) u_rs_chk (
    .clk        (clk),
    .rst        (rst),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .reti_i     (reti_i),
    .pop_addr_o (pop_addr_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .gie_clr_i  (gie_clr_i),
    .irq_ack_o  (irq_ack_o),
    .irq_flag_o (irq_flag_o),
    .gie_o      (gie_o)
);

// File: tb/test_ret_stack_irq.sv
module test_ret_stack_irq;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 15;
    localparam int NSRC = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            call_i, ret_i, reti_i;
    logic [AW-1:0]   push_addr_i;
    logic [AW-1:0]   pop_addr_o;
    logic            full_o, empty_o;
    logic [NSRC-1:0] irq_req_i, irq_en_i;
    logic            gie_set_i, gie_clr_i;
    logic [NSRC-1:0] irq_ack_o, irq_flag_o;
    logic            gie_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ret_stack_irq i_ret_stack_irq (
        .clk, .rst, .call_i, .ret_i, .reti_i, .push_addr_i, .pop_addr_o,
        .full_o, .empty_o, .irq_req_i, .irq_en_i, .gie_set_i, .gie_clr_i,
        .irq_ack_o, .irq_flag_o, .gie_o
    );

    typedef struct packed {
        logic          call;
        logic          ret;
        logic          reti;
        logic          gs;
        logic          gc;
        logic [2:0]    req;
        logic [2:0]    en;
        logic [14:0]   addr;
        logic [2:0]    e_ack;
        logic [14:0]   e_top;
        logic          e_empty;
        logic          e_full;
        logic          e_gie;
        logic [2:0]    e_flags;
        logic [3:0]    tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        // call ret reti gs gc req en addr | ack top empty full gie flags tag
        '{1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0100, 3'b000,15'h0100,1'b0,1'b0,1'b0,3'b000,4'd2},  // R2 store
        '{1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0200, 3'b000,15'h0200,1'b0,1'b0,1'b0,3'b000,4'd2},  // R2 newest shown
        '{1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b0,3'b000,4'd2},  // R2 remove
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b001,3'b000,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b0,3'b001,4'd6},  // R6 latch while disabled
        '{1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,3'b001,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b1,3'b001,4'd10}, // R10 set
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b001,15'h0333, 3'b001,15'h0333,1'b0,1'b0,1'b0,3'b000,4'd7},  // R7 ack stores, clears
        '{1'b0,1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b1,3'b000,4'd9},  // R9 reti sets gie
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b110,3'b110,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b1,3'b110,4'd6},  // R6 two requests
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b110,15'h0444, 3'b010,15'h0444,1'b0,1'b0,1'b0,3'b100,4'd7},  // R7 priority
        '{1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,3'b110,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b0,3'b100,4'd9},  // R9 ret keeps gie
        '{1'b0,1'b0,1'b0,1'b1,1'b1,3'b000,3'b110,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b0,3'b100,4'd10}, // R10 clear wins
        '{1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b1,3'b100,4'd11}, // R11 disabled
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b1,3'b100,4'd11}, // R11 still waits
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b100,15'h0555, 3'b100,15'h0555,1'b0,1'b0,1'b0,3'b000,4'd11}, // R11 enabled -> ack
        '{1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0666, 3'b000,15'h0666,1'b0,1'b0,1'b0,3'b000,4'd5},  // R5 swap top
        '{1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0000, 3'b000,15'h0100,1'b0,1'b0,1'b0,3'b000,4'd5},  // R5 depth kept
        '{1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,15'h0000, 3'b000,15'h0000,1'b1,1'b0,1'b0,3'b000,4'd2}   // R2 drained
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic ri,
                         input logic gs, input logic gc, input logic [2:0] rq,
                         input logic [2:0] en, input logic [14:0] a);
        @(negedge clk);
        call_i = c; ret_i = r; reti_i = ri; gie_set_i = gs; gie_clr_i = gc;
        irq_req_i = rq; irq_en_i = en; push_addr_i = a;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, '0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        call_i = 0; ret_i = 0; reti_i = 0; gie_set_i = 0; gie_clr_i = 0;
        irq_req_i = '0; irq_en_i = '0; push_addr_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 empty", empty_o, 1);
        chk("R1 full", full_o, 0);
        chk("R1 top", pop_addr_o, 0);
        chk("R1 gie", gie_o, 0);
        chk("R1 flags", irq_flag_o, 0);
        chk("R1 ack", irq_ack_o, 0);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].call, TBL[k].ret, TBL[k].reti, TBL[k].gs, TBL[k].gc,
                  TBL[k].req, TBL[k].en, TBL[k].addr);
            chk($sformatf("R%0d vec%0d ack", TBL[k].tag, k), irq_ack_o, TBL[k].e_ack);
            tick();
            chk($sformatf("R%0d vec%0d top", TBL[k].tag, k), pop_addr_o, TBL[k].e_top);
            chk($sformatf("R%0d vec%0d empty", TBL[k].tag, k), empty_o, TBL[k].e_empty);
            chk($sformatf("R%0d vec%0d full", TBL[k].tag, k), full_o, TBL[k].e_full);
            chk($sformatf("R%0d vec%0d gie", TBL[k].tag, k), gie_o, TBL[k].e_gie);
            chk($sformatf("R%0d vec%0d flags", TBL[k].tag, k), irq_flag_o, TBL[k].e_flags);
        end

        // R1 reset in mid-run clears a loaded stack and state
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010, 3'b000, 15'h0777);
        tick();
        @(negedge clk);
        call_i = 0; gie_set_i = 0; irq_req_i = '0; rst = 1'b1;
        tick();
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 mid empty", empty_o, 1);
        chk("R1 mid top", pop_addr_o, 0);
        chk("R1 mid gie", gie_o, 0);
        chk("R1 mid flags", irq_flag_o, 0);

        // R3 fill to eight levels
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, '0);
        tick();
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 15'(16 + k));
            tick();
            chk("R3 full flag while filling", full_o, (k == 7) ? 1 : 0);
        end
        chk("R3 top after fill", pop_addr_o, 15'h0017);

        // R8 request while full is kept, not acknowledged
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001, 15'h1234);
        chk("R8 ack full A", irq_ack_o, 0);
        tick();
        chk("R8 flag kept", irq_flag_o, 3'b001);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 15'h1234);
        chk("R8 ack full B", irq_ack_o, 0);
        tick();
        chk("R8 flag still kept", irq_flag_o, 3'b001);

        // R3 ninth call overwrites oldest silently
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 15'h7FFF);
        chk("R8 ack during call", irq_ack_o, 0);
        tick();
        chk("R3 full after overflow", full_o, 1);
        chk("R3 top after overflow", pop_addr_o, 15'h7FFF);

        // R8 pop frees a level; ack follows in next strobe-free cycle
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 15'h1234);
        chk("R8 ack during ret", irq_ack_o, 0);
        tick();
        chk("R8 not full after pop", full_o, 0);
        chk("R8 top after pop", pop_addr_o, 15'h0017);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 15'h1234);
        chk("R8 ack after room", irq_ack_o, 3'b001);
        tick();
        chk("R8 ack stored", pop_addr_o, 15'h1234);
        chk("R8 full again", full_o, 1);
        chk("R8 flag cleared", irq_flag_o, 0);
        chk("R7 gie cleared", gie_o, 0);

        // R3 drain: newest first, oldest (0x10) lost
        for (int k = 0; k < 8; k++) begin
            logic [14:0] exp_a;
            exp_a = (k == 0) ? 15'h1234 : 15'(24 - k);
            drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, '0);
            chk("R3 drain order", pop_addr_o, exp_a);
            tick();
        end
        chk("R3 empty after drain", empty_o, 1);

        // R4 pop on empty is ignored
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, '0);
        tick();
        chk("R4 still empty", empty_o, 1);
        chk("R4 top zero", pop_addr_o, 0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, '0);
        tick();
        chk("R4 reti empty", empty_o, 1);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 15'h0ABC);
        tick();
        chk("R4 store after empty pops", pop_addr_o, 15'h0ABC);
        chk("R4 not empty", empty_o, 0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, '0);
        tick();
        chk("R4 single level removed", empty_o, 1);
        idle();
        tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule